// File: doc/BRIEF.md
# Quad Driver Overcurrent Retry Controller

This block drives four output channels. A single enable gates all four. Each channel has its own request input, an overcurrent flag and a drive output. When a channel's overcurrent flag is raised, a per-channel protection latch trips and shuts that channel down. A retry timer shared by all channels later re-arms every tripped channel with a short pulse, so a persistent short produces a hiccup pattern rather than a permanent shutdown. A mode pin replaces the timed retry with manual re-arming from a key strobe.

An active-low fault output reports any tripped or overloaded channel. In timed-retry mode this output follows the retry pulse. An undervoltage flag blanks all drive outputs and releases the fault output. The overcurrent, undervoltage, request, enable, mode and key inputs are digital flags. Each of them passes through a two-flop synchronizer before any logic uses it.

Top module: `quad_drv_retry`

## Requirements
- R1: A drive output is high only when its request input is high, the shared enable is high, its latch is released and its overcurrent flag is low. The exception is the retry pulse (R4). A channel's drive output does not depend on the other channels.
- R2: When a channel's synchronized overcurrent flag goes high outside the retry pulse, that channel's drive output goes low in that same cycle, and its latch trips at the next clock edge.
- R3: The retry timer repeats a period of ON_UNITS+OFF_UNITS units (1+47 by default). Each unit lasts PRESCALE clock cycles, and the pulse is high during the first ON_UNITS units of the period.
- R4: While the retry pulse is high, tripped latches are cleared and outputs may drive even if overcurrent is still reported. A channel that still reports overcurrent after the pulse trips again.
- R5: After reset, every latch is released, the drive outputs are low and the fault output is high.
- R6: When the mode input is high (manual), the timer produces no pulse. A tripped latch is cleared only by a rising edge of the key input. One press clears the latch once, however long the key is held.
- R7: The fault output is low whenever any channel is tripped or reports overcurrent, except as set out in R8 and R9. Otherwise it is high.
- R8: In timed-retry mode, while a fault is present, the fault output is high during the retry pulse and low for the rest of the period.
- R9: While undervoltage is flagged, all drive outputs are low and the fault output is high, whatever the other inputs are.
- R10: Every input reaches the outputs through two synchronizer flops. A change applied before clock edge k shows at the outputs after edge k+1.
- R11: When undervoltage clears, all latches are released and the retry timer starts a new period from its first unit, so the pulse is high at once in timed-retry mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| data_i | input | NCH | Per-channel drive request, active high |
| enable_i | input | 1 | Shared enable, active high |
| oc_i | input | NCH | Per-channel overcurrent flag, active high |
| uv_i | input | 1 | Undervoltage flag, active high |
| manual_i | input | 1 | 1 = re-arm by key, 0 = timed retry |
| key_i | input | 1 | Manual re-arm key |
| drv_o | output | NCH | Gated drive outputs |
| fault_n_o | output | 1 | Fault indication, active low |

## Verification
The block is exercised with four kinds of stimulus:

- **Steady requests with no faults.** These confirm plain gating and the two-cycle input latency.
- **A single overcurrent held through several timer periods.** This measures the length of the retry pulse against the full period, on both the fault output and the tripped channel. It also confirms that a neighbouring channel keeps driving.
- **Short overcurrent bursts in manual mode with held and repeated key presses.** These separate edge-triggered release from level-triggered release, and confirm that the timer never re-arms a channel in this mode.
- **Random mixes of all inputs, including undervoltage toggling.** These are compared each cycle against a reference model. They show whether undervoltage blanking and the timer restart are correct relative to the other inputs.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  parameter int QDR_NCH = 4;
  parameter int QDR_SYNC_STAGES = 2;
endpackage

// File: rtl/qdr_sync.sv
module qdr_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] meta_d;
  logic [W-1:0] out_d;

  always_comb begin
    meta_d = d_i;
    out_d  = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= meta_d;
      q_o    <= out_d;
    end
  end
endmodule

// File: rtl/qdr_retry_timer.sv
module qdr_retry_timer #(
  parameter int PRESCALE  = 4,
  parameter int ON_UNITS  = 1,
  parameter int OFF_UNITS = 47
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic pulse_o
);
  localparam int PERIOD = ON_UNITS + OFF_UNITS;
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int UW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] PRE_LAST  = PW'(PRESCALE - 1);
  localparam logic [UW-1:0] UNIT_LAST = UW'(PERIOD - 1);
  localparam logic [UW-1:0] UNIT_ON   = UW'(ON_UNITS);

  logic [PW-1:0] pre_q, pre_d;
  logic [UW-1:0] unit_q, unit_d;
  logic          tick;

  always_comb begin
    tick   = (pre_q == PRE_LAST);
    pre_d  = pre_q;
    unit_d = unit_q;
    if (hold_i) begin
      pre_d  = '0;
      unit_d = '0;
    end else if (tick) begin
      pre_d  = '0;
      unit_d = (unit_q == UNIT_LAST) ? '0 : unit_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else begin
      pre_q  <= pre_d;
      unit_q <= unit_d;
    end
  end

  assign pulse_o = !hold_i && (unit_q < UNIT_ON);

  AST_UNIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    unit_q <= UNIT_LAST); // R3
  AST_HOLD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (unit_q == '0 && pre_q == '0)); // R11
endmodule

// File: rtl/qdr_chan.sv
module qdr_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic oc_i,
  input  logic uv_i,
  input  logic pulse_i,
  input  logic key_rel_i,
  output logic trip_o,
  output logic drv_o
);
  logic trip_q, trip_d;

  always_comb begin
    trip_d = trip_q;
    if (uv_i) begin
      trip_d = 1'b0;
    end else if (oc_i && !pulse_i) begin
      trip_d = 1'b1;
    end else if (pulse_i || key_rel_i) begin
      trip_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trip_q <= 1'b0;
    else        trip_q <= trip_d;
  end

  assign trip_o = trip_q;
  assign drv_o  = req_i && !uv_i && (pulse_i || (!trip_q && !oc_i));

  AST_TRIP_ON_OC: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_i && !pulse_i && !uv_i) |=> trip_q); // R2
  AST_PULSE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i && !uv_i) |=> !trip_q); // R4
  AST_UV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> !trip_q); // R11
  AST_TRIPPED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && !pulse_i) |-> !drv_o); // R1
endmodule

// File: rtl/quad_drv_retry.sv
module quad_drv_retry
  import qdr_pkg::*;
#(
  parameter int NCH       = QDR_NCH,
  parameter int PRESCALE  = 4,
  parameter int ON_UNITS  = 1,
  parameter int OFF_UNITS = 47
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] data_i,
  input  logic           enable_i,
  input  logic [NCH-1:0] oc_i,
  input  logic           uv_i,
  input  logic           manual_i,
  input  logic           key_i,
  output logic [NCH-1:0] drv_o,
  output logic           fault_n_o
);
  localparam int SW = 2 * NCH + 4;

  logic           rst_m_q, rst_int_n;
  logic [NCH-1:0] data_s, oc_s, trip;
  logic           en_s, uv_s, man_s, key_s, key_d_q;
  logic           key_rise, key_rel, pulse, fault_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q   <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_m_q   <= 1'b1;
      rst_int_n <= rst_m_q;
    end
  end

  qdr_sync #(.W(SW)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({data_i, oc_i, enable_i, uv_i, manual_i, key_i}),
    .q_o   ({data_s, oc_s, en_s, uv_s, man_s, key_s})
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) key_d_q <= 1'b0;
    else            key_d_q <= key_s;
  end

  assign key_rise = key_s && !key_d_q;
  assign key_rel  = man_s && key_rise;

  qdr_retry_timer #(
    .PRESCALE  (PRESCALE),
    .ON_UNITS  (ON_UNITS),
    .OFF_UNITS (OFF_UNITS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .hold_i  (uv_s || man_s),
    .pulse_o (pulse)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    qdr_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .req_i     (data_s[g] && en_s),
      .oc_i      (oc_s[g]),
      .uv_i      (uv_s),
      .pulse_i   (pulse),
      .key_rel_i (key_rel),
      .trip_o    (trip[g]),
      .drv_o     (drv_o[g])
    );
  end

  always_comb begin
    fault_any = (|trip) || (|oc_s);
    if (uv_s || !fault_any) fault_n_o = 1'b1;
    else if (man_s)         fault_n_o = 1'b0;
    else                    fault_n_o = pulse;
  end

  AST_UV_BLANK: assert property (@(posedge clk) disable iff (!rst_int_n)
    uv_s |-> (drv_o == '0 && fault_n_o)); // R9
  AST_KEY_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    key_rise |=> !key_rise); // R6
  AST_MANUAL_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    man_s |-> !pulse); // R6
endmodule

// File: tb/test_quad_drv_retry.sv
module test_quad_drv_retry;
  localparam int NCH = 4;
  localparam int PRE = 2;
  localparam int PER = 48;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] data_i = '0;
  logic           enable_i = 1'b0;
  logic [NCH-1:0] oc_i = '0;
  logic           uv_i = 1'b0;
  logic           manual_i = 1'b0;
  logic           key_i = 1'b0;
  logic [NCH-1:0] drv_o;
  logic           fault_n_o;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  quad_drv_retry #(.NCH(NCH), .PRESCALE(PRE), .ON_UNITS(1), .OFF_UNITS(47)) i_quad_drv_retry (
    .clk(clk), .rst_n(rst_n), .data_i(data_i), .enable_i(enable_i), .oc_i(oc_i),
    .uv_i(uv_i), .manual_i(manual_i), .key_i(key_i), .drv_o(drv_o), .fault_n_o(fault_n_o)
  );

  // reference model built from the requirements
  logic           m_r1, m_r2;
  logic [NCH-1:0] m_d1, m_d2, m_o1, m_o2, m_trip;
  logic           m_e1, m_e2, m_u1, m_u2, m_m1, m_m2, m_k1, m_k2, m_kp;
  int             m_pre, m_unit;
  logic           m_pulse;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_r1 <= 1'b0; m_r2 <= 1'b0; end
    else begin m_r1 <= 1'b1; m_r2 <= m_r1; end
  end

  assign m_pulse = (m_unit == 0) && !m_u2 && !m_m2;

  always @(posedge clk or negedge m_r2) begin
    if (!m_r2) begin
      m_d1 <= '0; m_d2 <= '0; m_o1 <= '0; m_o2 <= '0; m_trip <= '0;
      {m_e1, m_e2, m_u1, m_u2, m_m1, m_m2, m_k1, m_k2, m_kp} <= '0;
      m_pre <= 0; m_unit <= 0;
    end else begin
      m_d1 <= data_i; m_d2 <= m_d1; m_o1 <= oc_i; m_o2 <= m_o1;
      m_e1 <= enable_i; m_e2 <= m_e1; m_u1 <= uv_i; m_u2 <= m_u1;
      m_m1 <= manual_i; m_m2 <= m_m1; m_k1 <= key_i; m_k2 <= m_k1; m_kp <= m_k2;
      if (m_u2 || m_m2) begin m_pre <= 0; m_unit <= 0; end
      else if (m_pre == PRE - 1) begin m_pre <= 0; m_unit <= (m_unit == PER - 1) ? 0 : m_unit + 1; end
      else m_pre <= m_pre + 1;
      for (int i = 0; i < NCH; i++) begin
        if (m_u2) m_trip[i] <= 1'b0;
        else if (m_o2[i] && !m_pulse) m_trip[i] <= 1'b1;
        else if (m_pulse || (m_m2 && m_k2 && !m_kp)) m_trip[i] <= 1'b0;
      end
    end
  end

  function automatic logic [NCH-1:0] f_drv();
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++)
      r[i] = m_d2[i] && m_e2 && !m_u2 && (m_pulse || (!m_trip[i] && !m_o2[i]));
    return r;
  endfunction

  function automatic logic f_fault();
    if (m_u2 || !((|m_trip) || (|m_o2))) return 1'b1;
    if (m_m2) return 1'b0;
    return m_pulse;
  endfunction

  task automatic chk(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R1/R2/R4/R9 model drive", drv_o, f_drv());
      chk("R7/R8/R9 model fault", {{(NCH-1){1'b0}}, fault_n_o}, {{(NCH-1){1'b0}}, f_fault()});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 20ns);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int hi_f, hi_d2, hi_d0;
    void'($urandom(32'd1234));
    cyc(5);
    chk("R5 reset drive", drv_o, '0);
    chk("R5 reset fault", {3'b0, fault_n_o}, 4'b0001);
    rst_n = 1'b1;
    data_i = 4'hF; enable_i = 1'b1;
    cyc(8);
    cmp_en = 1'b1;
    chk("R5 latches released after reset", drv_o, 4'hF);
    // R10 latency
    data_i = 4'b0101;
    cyc(1);
    chk("R10 one edge later unchanged", drv_o, 4'hF);
    cyc(1);
    chk("R10 two edges later changed", drv_o, 4'b0101);
    data_i = 4'hF; enable_i = 1'b0;
    cyc(2);
    chk("R1 enable gates all", drv_o, 4'h0);
    enable_i = 1'b1;
    // manual mode trip and key release
    manual_i = 1'b1;
    cyc(4);
    oc_i = 4'b0010;
    cyc(2);
    chk("R2 overcurrent turns channel off", drv_o, 4'b1101);
    chk("R7 fault low in manual", {3'b0, fault_n_o}, 4'b0000);
    oc_i = 4'b0000;
    cyc(200);
    chk("R6 no timer release in manual", drv_o, 4'b1101);
    key_i = 1'b1;
    cyc(4);
    chk("R6 key press releases", drv_o, 4'hF);
    oc_i = 4'b1000;
    cyc(4);
    oc_i = 4'b0000;
    cyc(6);
    chk("R6 held key gives one release only", drv_o, 4'b0111);
    key_i = 1'b0;
    cyc(4);
    chk("R6 key fall does not release", drv_o, 4'b0111);
    key_i = 1'b1;
    cyc(4);
    chk("R6 second press releases", drv_o, 4'hF);
    key_i = 1'b0;
    // timed retry with persistent fault on channel 2
    manual_i = 1'b0; oc_i = 4'b0100;
    cyc(2 * PER * PRE);
    hi_f = 0; hi_d2 = 0; hi_d0 = 0;
    for (int k = 0; k < PER * PRE; k++) begin
      @(negedge clk);
      hi_f  += fault_n_o;
      hi_d2 += drv_o[2];
      hi_d0 += drv_o[0];
    end
    chk("R3/R8 fault high cycles per period", 4'(hi_f), 4'(PRE));
    chk("R4 retry pulse drives faulted channel", 4'(hi_d2), 4'(PRE));
    n_chk++;
    if (hi_d0 != PER * PRE) begin
      n_bad++;
      $display("FAIL R1 neighbour channel actual=%0d expected=%0d", hi_d0, PER * PRE);
    end
    // undervoltage blanking and restart
    uv_i = 1'b1;
    cyc(2);
    chk("R9 uv drive off", drv_o, 4'h0);
    chk("R9 uv fault released", {3'b0, fault_n_o}, 4'b0001);
    uv_i = 1'b0;
    cyc(2);
    chk("R11 pulse at once after uv", {3'b0, fault_n_o}, 4'b0001);
    chk("R11 drive during restart pulse", drv_o, 4'hF);
    cyc(PRE);
    chk("R11 retrip after first unit", {3'b0, fault_n_o}, 4'b0000);
    // random mix
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) data_i = 4'($urandom);
      if ($urandom_range(0, 31) == 0) enable_i = ~enable_i;
      if ($urandom_range(0, 15) == 0) oc_i = 4'($urandom) & 4'($urandom);
      if ($urandom_range(0, 199) == 0) uv_i = ~uv_i;
      if ($urandom_range(0, 299) == 0) manual_i = ~manual_i;
      if ($urandom_range(0, 7) == 0) key_i = ~key_i;
    end
    cyc(2);
    finish_run();
  end
endmodule